// File: doc/BRIEF.md
# Banked Pin Controller with Half-Word Masked Writes

This block is a memory-mapped general-purpose pin controller for up to four banks of 32 pins. Software reaches it over a plain 32-bit register bus with a write strobe, a read strobe and a byte address. Each bank holds three registers: the output level of each pin, a direction bit per pin and an output-enable bit per pin. A pin drives its pad only when both its direction and its output-enable bits are set. This means a pin configured as an output can still be tri-stated.

Output levels can be changed in three ways. A full 32-bit write to the bank's direct output register replaces every level. A toggle is done by reading that register back, changing it and writing it again. Two masked write ports per bank, one for each 16-bit half, change only selected bits in a single bus write, so no read-modify-write is needed. A fourth read-only register per bank returns the pin levels after a two-flop synchronizer. One bank, bank 1 by default, is narrower than the others. Its missing pins read as zero and cannot be set by any write.

Top module: `banked_pin_ctrl`

## Requirements
- R1: After the synchronous active-high reset, every output level, direction bit and output-enable bit is 0, so `pin_out` and `pin_oe` are all zero and `bus_rdata` is 0.
- R2: A write to the low masked port of bank b (byte offset 8*b) uses write bits 31:16 as a keep-mask for pins 15:0 of that bank. Where a mask bit is 1 the level is kept. Where it is 0 the level takes the matching bit from write bits 15:0. Pins 31:16 do not change.
- R3: A write to the high masked port of bank b (byte offset 8*b+4) applies the same keep-mask rule to pins 31:16 of that bank, taking the data from write bits 15:0. Pins 15:0 do not change.
- R4: The direct output register of bank b (offset 0x40+4*b) accepts a full 32-bit write and reads back the current levels. Bit i of bank b drives `pin_out[32*b+i]`.
- R5: The input register of bank b (offset 0x60+4*b) returns `pin_in[32*b+i]` in bit i after two synchronizing flops. Writes to this register change nothing.
- R6: The direction register of bank b (offset 0x204+0x40*b) is read/write. A 1 marks the pin as an output.
- R7: The output-enable register of bank b (offset 0x208+0x40*b) is read/write. `pin_oe[32*b+i]` is 1 exactly when both the direction bit and the output-enable bit of that pin are 1.
- R8: In the narrow bank, register bits above the last existing pin (bits 31:22 of bank 1 by default) read as 0 and ignore every write, including masked writes. Their `pin_out`, `pin_oe` and input bits stay 0.
- R9: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe is sampled. In any cycle without a read in the previous cycle, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_out | output | 128 | Output level per pin |
| pin_oe | output | 128 | Drive enable per pin (1 = drive) |
| pin_in | input | 128 | Sampled pad level per pin |

## Verification
The hardest case to reach is a sequence that mixes the three kinds of output writes on one bank, in particular a masked write to one half landing between a direct write and the read-back used for a toggle. If the two halves or the two write paths were coupled, it would only show up there. The random stimulus therefore picks the bank, the register kind and the mask bits independently, with masks that are mostly dense and mostly sparse. It does this over several hundred serialized writes, and after each write it compares every pin against a bench model. Directed cases then hit the narrow bank's missing bits, the all-keep and all-apply masks, an output pin with drive disabled, and writes to the input register and to unmapped offsets.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    K_NONE, K_MASK_LO, K_MASK_HI, K_LEVEL, K_SAMPLE, K_DIR, K_ENABLE
  } reg_kind_e;

  // Bits that exist in bank b; the narrow bank keeps only its low pins.
  function automatic logic [WORD_W-1:0] bank_valid(int b, int narrow_bank, int narrow_pins);
    logic [WORD_W-1:0] m;
    m = '1;
    if (b == narrow_bank) m = (WORD_W'(1) << narrow_pins) - WORD_W'(1);
    return m;
  endfunction
endpackage

// File: rtl/pinctl_decode.sv
module pinctl_decode
  import pinctl_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int BANK_IW   = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  output reg_kind_e          kind,
  output logic [BANK_IW-1:0] bank
);
  always_comb begin
    kind = K_NONE;
    bank = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(8*b))               begin kind = K_MASK_LO; bank = BANK_IW'(b); end
      if (addr == ADDR_W'(8*b + 4))           begin kind = K_MASK_HI; bank = BANK_IW'(b); end
      if (addr == ADDR_W'(32'h40 + 4*b))      begin kind = K_LEVEL;   bank = BANK_IW'(b); end
      if (addr == ADDR_W'(32'h60 + 4*b))      begin kind = K_SAMPLE;  bank = BANK_IW'(b); end
      if (addr == ADDR_W'(32'h204 + 'h40*b))  begin kind = K_DIR;     bank = BANK_IW'(b); end
      if (addr == ADDR_W'(32'h208 + 'h40*b))  begin kind = K_ENABLE;  bank = BANK_IW'(b); end
    end
  end
endmodule

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pinctl_bank.sv
module pinctl_bank
  import pinctl_pkg::*;
#(
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  reg_kind_e   kind,
  input  logic [31:0] wdata,
  output logic [31:0] level_q,
  output logic [31:0] dir_q,
  output logic [31:0] ena_q,
  output logic [31:0] drive_q
);
  logic [31:0] level_d, dir_d, ena_d;
  logic [HALF_W-1:0] keep, val;

  assign keep = wdata[WORD_W-1:HALF_W];
  assign val  = wdata[HALF_W-1:0];

  always_comb begin
    level_d = level_q;
    dir_d   = dir_q;
    ena_d   = ena_q;
    if (we) begin
      case (kind)
        K_MASK_LO: level_d[HALF_W-1:0] = (level_q[HALF_W-1:0] & keep) | (val & ~keep);
        K_MASK_HI: level_d[WORD_W-1:HALF_W] = (level_q[WORD_W-1:HALF_W] & keep) | (val & ~keep);
        K_LEVEL:   level_d = wdata;
        K_DIR:     dir_d   = wdata;
        K_ENABLE:  ena_d   = wdata;
        default:   ;
      endcase
    end
    level_d = level_d & VALID;
    dir_d   = dir_d & VALID;
    ena_d   = ena_d & VALID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      dir_q   <= '0;
      ena_q   <= '0;
      drive_q <= '0;
    end else begin
      level_q <= level_d;
      dir_q   <= dir_d;
      ena_q   <= ena_d;
      drive_q <= dir_d & ena_d;
    end
  end
endmodule

// File: rtl/banked_pin_ctrl.sv
module banked_pin_ctrl
  import pinctl_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 12,
  parameter int NARROW_BANK = 1,
  parameter int NARROW_PINS = 22
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [WORD_W-1:0]             bus_wdata,
  output logic [WORD_W-1:0]             bus_rdata,
  output logic [NUM_BANKS*WORD_W-1:0]   pin_out,
  output logic [NUM_BANKS*WORD_W-1:0]   pin_oe,
  input  logic [NUM_BANKS*WORD_W-1:0]   pin_in
);
  localparam int PINS    = NUM_BANKS * WORD_W;
  localparam int BANK_IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  reg_kind_e          kind;
  logic [BANK_IW-1:0] bank;
  logic [PINS-1:0]    sampled;

  logic [WORD_W-1:0] level_a  [NUM_BANKS];
  logic [WORD_W-1:0] dir_a    [NUM_BANKS];
  logic [WORD_W-1:0] ena_a    [NUM_BANKS];
  logic [WORD_W-1:0] sample_a [NUM_BANKS];

  pinctl_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_IW(BANK_IW)) u_dec (
    .addr(bus_addr), .kind(kind), .bank(bank)
  );

  pinctl_sync #(.W(PINS)) u_sync (.clk(clk), .rst(rst), .d(pin_in), .q(sampled));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [WORD_W-1:0] VMASK = bank_valid(b, NARROW_BANK, NARROW_PINS);
    logic [WORD_W-1:0] drive;

    pinctl_bank #(.VALID(VMASK)) u_bank (
      .clk(clk), .rst(rst),
      .we(bus_wr && (bank == BANK_IW'(b))),
      .kind(kind), .wdata(bus_wdata),
      .level_q(level_a[b]), .dir_q(dir_a[b]), .ena_q(ena_a[b]), .drive_q(drive)
    );

    assign sample_a[b] = sampled[b*WORD_W +: WORD_W] & VMASK;
    assign pin_out[b*WORD_W +: WORD_W] = level_a[b];
    assign pin_oe[b*WORD_W +: WORD_W]  = drive;
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (kind)
        K_LEVEL:  bus_rdata <= level_a[bank];
        K_SAMPLE: bus_rdata <= sample_a[bank];
        K_DIR:    bus_rdata <= dir_a[bank];
        K_ENABLE: bus_rdata <= ena_a[bank];
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pinctl_checker.sv
module pinctl_checker #(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 12,
  parameter int NARROW_BANK = 1,
  parameter int NARROW_PINS = 22
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic [NUM_BANKS*32-1:0]     pin_out,
  input logic [NUM_BANKS*32-1:0]     pin_oe
);
  localparam int GAP_LO = NARROW_BANK*32 + NARROW_PINS;
  localparam int GAP_W  = 32 - NARROW_PINS;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  assert_mask_lo_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == '0) |->
      (pin_out[15:0] == (($past(pin_out[15:0]) & $past(bus_wdata[31:16])) |
                         ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16])))) &&
      (pin_out[31:16] == $past(pin_out[31:16])));

  assert_sample_write_inert_R5: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == ADDR_W'('h60)) |-> ($stable(pin_out) && $stable(pin_oe)));

  assert_gap_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (pin_out[GAP_LO +: GAP_W] == '0) && (pin_oe[GAP_LO +: GAP_W] == '0));

  assert_unmapped_inert_R9: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && bus_addr == ADDR_W'('h100)) |-> ($stable(pin_out) && $stable(pin_oe)));

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> bus_rdata == '0);
endmodule

bind banked_pin_ctrl pinctl_checker #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .NARROW_BANK(NARROW_BANK), .NARROW_PINS(NARROW_PINS)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_banked_pin_ctrl.sv
module sim_banked_pin_ctrl;
  logic         clk = 0;
  logic         rst = 1;
  logic         bus_wr = 0, bus_rd = 0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_out, pin_oe;
  logic [127:0] pin_in = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_lvl [4];
  logic [31:0] m_dir [4];
  logic [31:0] m_ena [4];

  always #5 clk = ~clk;

  banked_pin_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  function automatic logic [31:0] vmask(int b);
    return (b == 1) ? 32'h003F_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    for (int b = 0; b < 4; b++) begin
      if (a == 12'(32'h40 + 4*b))     return m_lvl[b];
      if (a == 12'(32'h60 + 4*b))     return pin_in[b*32 +: 32] & vmask(b);
      if (a == 12'(32'h204 + 64*b))   return m_dir[b];
      if (a == 12'(32'h208 + 64*b))   return m_ena[b];
    end
    return 32'h0;
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    for (int b = 0; b < 4; b++) begin
      if (a == 12'(8*b))
        m_lvl[b][15:0] = (m_lvl[b][15:0] & d[31:16]) | (d[15:0] & ~d[31:16]);
      if (a == 12'(8*b + 4))
        m_lvl[b][31:16] = (m_lvl[b][31:16] & d[31:16]) | (d[15:0] & ~d[31:16]);
      if (a == 12'(32'h40 + 4*b))   m_lvl[b] = d;
      if (a == 12'(32'h204 + 64*b)) m_dir[b] = d;
      if (a == 12'(32'h208 + 64*b)) m_ena[b] = d;
      m_lvl[b] &= vmask(b); m_dir[b] &= vmask(b); m_ena[b] &= vmask(b);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    model_write(a, d);
  endtask

  task automatic rd_check(string req, logic [11:0] a);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic pins_check(string req);
    for (int b = 0; b < 4; b++) begin
      chk(req, pin_out[b*32 +: 32], m_lvl[b]);
      chk(req, pin_oe[b*32 +: 32], m_dir[b] & m_ena[b]);
    end
  endtask

  task automatic set_inputs(logic [127:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [11:0] rand_addr();
    int b, k;
    b = $urandom_range(0, 3);
    k = $urandom_range(0, 6);
    case (k)
      0: return 12'(8*b);
      1: return 12'(8*b + 4);
      2: return 12'(32'h40 + 4*b);
      3: return 12'(32'h60 + 4*b);
      4: return 12'(32'h204 + 64*b);
      5: return 12'(32'h208 + 64*b);
      default: return 12'h100 + 12'($urandom_range(0, 15) * 4);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < 4; b++) begin m_lvl[b] = 0; m_dir[b] = 0; m_ena[b] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    pins_check("R1");
    chk("R1", bus_rdata, 32'h0);
    rd_check("R1", 12'h204);

    // R4 direct write and readback
    wr(12'h040, 32'hA5A5_0F0F);
    pins_check("R4");
    rd_check("R4", 12'h040);
    // R2 low masked write: keep all, then apply all, then mixed
    wr(12'h000, 32'hFFFF_0000);
    pins_check("R2");
    wr(12'h000, 32'h0000_1234);
    pins_check("R2");
    wr(12'h000, 32'hFF00_00FF);
    pins_check("R2");
    // R3 high masked write
    wr(12'h004, 32'h00FF_BEEF);
    pins_check("R3");
    rd_check("R3", 12'h040);
    // R8 narrow bank upper bits
    wr(12'h044, 32'hFFFF_FFFF);
    rd_check("R8", 12'h044);
    chk("R8", pin_out[63:32], 32'h003F_FFFF);
    wr(12'h00C, 32'h0000_FFFF);
    chk("R8", pin_out[63:32], 32'h003F_FFFF);
    // R6/R7 direction with drive disabled, then enabled
    wr(12'h204, 32'hFFFF_FFFF);
    pins_check("R7");
    rd_check("R6", 12'h204);
    wr(12'h208, 32'h0000_FF00);
    pins_check("R7");
    rd_check("R7", 12'h208);
    wr(12'h244, 32'hFFFF_FFFF);
    wr(12'h248, 32'hFFFF_FFFF);
    pins_check("R8");
    // R5 input path and inert write
    set_inputs({32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFF, 32'hCAFE_F00D});
    rd_check("R5", 12'h060);
    rd_check("R5", 12'h064);
    wr(12'h060, 32'hFFFF_FFFF);
    pins_check("R5");
    rd_check("R5", 12'h060);
    // R9 unmapped
    wr(12'h100, 32'hFFFF_FFFF);
    pins_check("R9");
    rd_check("R9", 12'h100);
    rd_check("R9", 12'hFFC);
    // R10 idle rdata
    @(negedge clk);
    chk("R10", bus_rdata, 32'h0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = rand_addr();
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d[31:16] = 16'($urandom() & $urandom());
      if ($urandom_range(0, 3) == 0) d[31:16] = 16'($urandom() | $urandom());
      if ($urandom_range(0, 1) == 0) begin
        wr(a, d);
        pins_check("R2 R3 R4 R7");
      end else begin
        rd_check("R4 R6 R10", a);
      end
      if (i % 60 == 0) begin
        set_inputs({$urandom(), $urandom(), $urandom(), $urandom()});
        for (int b = 0; b < 4; b++) rd_check("R5", 12'(32'h60 + 4*b));
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule